// File: doc/BRIEF.md
# DRAM Row Refresh Scheduler

This block sits between an access request port and a DRAM array model and guarantees that every row of the array is refreshed before its stored charge decays past the sense threshold. A free-running interval timer raises one refresh demand every `INTERVAL` cycles. The refreshes are therefore spread evenly over the retention window instead of being issued in bursts. Each demand refreshes the row named by a wrapping row pointer. The refresh holds the array for `REF_CYCLES` cycles, and during that time new accesses are held off.

Accesses use a valid/ready handshake. An accepted access holds the array for `ACC_CYCLES` cycles. A refresh that becomes due while an access is in flight waits for that access to finish. It then wins over any request already waiting. Two counters record the overhead: the cycles spent refreshing, and the cycles in which a request was stalled. The refresh share of array time can be read directly from them.

With the defaults, the array has 16K rows, a retention window of 50 ms and a row refresh time of 100 ns, at 1 ns per cycle. One full sweep then costs about 1.64 ms, which is roughly 3.3% of array time. Rows are abstract indices. The array's own pin timing is outside this block.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset, `refresh_busy` and `acc_busy` are 0, `refresh_row` is 0, both counters are 0 and `req_ready` is 1.
- R2: With no access traffic, successive refreshes begin exactly `INTERVAL` cycles apart.
- R3: Each refresh holds `refresh_busy` high for exactly `REF_CYCLES` consecutive cycles.
- R4: `refresh_row` names the row being refreshed and advances by one when a refresh ends, going from `ROWS-1` back to 0.
- R5: A request is accepted in a cycle where `req_valid` and `req_ready` are both 1. `acc_busy` is then high for exactly `ACC_CYCLES` cycles, starting in the next cycle.
- R6: `req_ready` is 0 whenever the array is busy or a refresh is due. A refresh and an access never hold the array in the same cycle.
- R7: A refresh that falls due during an access starts in the first idle cycle after that access. A request held valid across that period is accepted only after the refresh ends.
- R8: `lost_cycles` increases by one for every cycle with `refresh_busy` high. Over one full sweep it grows by `ROWS*REF_CYCLES`, which is a share of about REF_CYCLES/INTERVAL of the elapsed cycles (about 3.3% at the nominal ratio).
- R9: `stall_cycles` increases by one for every cycle in which `req_valid` is 1 and `req_ready` is 0.
- R10: No row goes longer than `WINDOW` cycles between refreshes. Reset counts as a refresh of every row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_ready | output | 1 | Request accepted this cycle if valid |
| acc_busy | output | 1 | Array occupied by an access |
| refresh_busy | output | 1 | Array occupied by a row refresh |
| refresh_row | output | ROW_W | Row being refreshed, or next to be refreshed |
| lost_cycles | output | CNT_W | Cycles spent refreshing since reset |
| stall_cycles | output | CNT_W | Cycles a valid request waited since reset |

## Verification
The bound checker watches several properties on every cycle. Refresh and access never overlap. Ready stays low while the array is busy. Every refresh and every access has its exact length, and the row pointer steps and wraps as required. Both overhead counters step only on the right cycles. A retention-age counter flags any sweep that leaves row 0 unrefreshed for longer than the window. Some behaviours only the bench scenarios can show. These are the spacing of refresh demands, the priority of a pending refresh over a request that waited through an access, the exact waits seen by requests placed just before, during and after a refresh, and the measured refresh share over one whole sweep.

// File: rtl/dram_ref_pkg.sv
package dram_ref_pkg;

    typedef enum logic [1:0] {
        ARB_IDLE    = 2'd0,
        ARB_ACCESS  = 2'd1,
        ARB_REFRESH = 2'd2
    } arb_state_e;

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ref_interval_timer.sv
module ref_interval_timer #(
    parameter int unsigned INTERVAL = 3000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_ack,
    output logic pending
);
    localparam int unsigned TW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
        logic          pend;
    } tmr_t;

    tmr_t st_d, st_q;
    logic tick;

    always_comb begin
        st_d = st_q;
        tick = (st_q.cnt == LAST);
        st_d.cnt = tick ? '0 : st_q.cnt + 1'b1;
        st_d.pend = (st_q.pend & ~start_ack) | tick;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pend;
endmodule

// File: rtl/ref_row_counter.sv
module ref_row_counter #(
    parameter int unsigned ROWS  = 16384,
    parameter int unsigned ROW_W = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [ROW_W-1:0] row
);
    localparam logic [ROW_W-1:0] TOP = ROW_W'(ROWS - 1);

    logic [ROW_W-1:0] row_d, row_q;

    always_comb begin
        row_d = row_q;
        if (advance) begin
            row_d = (row_q == TOP) ? '0 : row_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
        end else begin
            row_q <= row_d;
        end
    end

    assign row = row_q;
endmodule

// File: rtl/ref_arbiter.sv
module ref_arbiter
    import dram_ref_pkg::*;
#(
    parameter int unsigned REF_CYCLES = 100,
    parameter int unsigned ACC_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pending,
    input  logic req_valid,
    output logic req_ready,
    output logic acc_busy,
    output logic ref_busy,
    output logic ref_start,
    output logic ref_done
);
    localparam int unsigned MAXC = max_u(REF_CYCLES, ACC_CYCLES);
    localparam int unsigned CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] REF_LOAD = CW'(REF_CYCLES - 1);
    localparam logic [CW-1:0] ACC_LOAD = CW'(ACC_CYCLES - 1);

    typedef struct packed {
        arb_state_e    state;
        logic [CW-1:0] left;
    } arb_t;

    arb_t st_d, st_q;
    logic idle;
    logic last;

    always_comb begin
        st_d      = st_q;
        idle      = (st_q.state == ARB_IDLE);
        last      = (st_q.left == '0);
        ref_start = idle && pending;
        ref_done  = (st_q.state == ARB_REFRESH) && last;
        req_ready = idle && !pending;
        unique case (st_q.state)
            ARB_IDLE: begin
                if (pending) begin
                    st_d.state = ARB_REFRESH;
                    st_d.left  = REF_LOAD;
                end else if (req_valid) begin
                    st_d.state = ARB_ACCESS;
                    st_d.left  = ACC_LOAD;
                end
            end
            ARB_ACCESS, ARB_REFRESH: begin
                if (last) begin
                    st_d.state = ARB_IDLE;
                end else begin
                    st_d.left = st_q.left - 1'b1;
                end
            end
            default: st_d.state = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{state: ARB_IDLE, left: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_busy = (st_q.state == ARB_ACCESS);
    assign ref_busy = (st_q.state == ARB_REFRESH);
endmodule

// File: rtl/ref_stat_counters.sv
module ref_stat_counters #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_busy,
    input  logic             stalled,
    output logic [CNT_W-1:0] lost,
    output logic [CNT_W-1:0] stall
);
    typedef struct packed {
        logic [CNT_W-1:0] lost;
        logic [CNT_W-1:0] stall;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ref_busy) st_d.lost  = st_q.lost + 1'b1;
        if (stalled)  st_d.stall = st_q.stall + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lost  = st_q.lost;
    assign stall = st_q.stall;
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched #(
    parameter int unsigned ROWS       = 16384,
    parameter int unsigned WINDOW     = 50000000,
    parameter int unsigned INTERVAL   = 3000,
    parameter int unsigned REF_CYCLES = 100,
    parameter int unsigned ACC_CYCLES = 4,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned ROW_W      = $clog2(ROWS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    output logic             acc_busy,
    output logic             refresh_busy,
    output logic [ROW_W-1:0] refresh_row,
    output logic [CNT_W-1:0] lost_cycles,
    output logic [CNT_W-1:0] stall_cycles
);
    localparam int unsigned SWEEP = ROWS * INTERVAL;

    logic pending;
    logic ref_start;
    logic ref_done;

    initial begin
        if (SWEEP > WINDOW) $error("refresh sweep longer than retention window");
    end

    ref_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_ack (ref_start),
        .pending   (pending)
    );

    ref_arbiter #(.REF_CYCLES(REF_CYCLES), .ACC_CYCLES(ACC_CYCLES)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .pending   (pending),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .acc_busy  (acc_busy),
        .ref_busy  (refresh_busy),
        .ref_start (ref_start),
        .ref_done  (ref_done)
    );

    ref_row_counter #(.ROWS(ROWS), .ROW_W(ROW_W)) u_rows (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (ref_done),
        .row     (refresh_row)
    );

    ref_stat_counters #(.CNT_W(CNT_W)) u_stats (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_busy (refresh_busy),
        .stalled  (req_valid && !req_ready),
        .lost     (lost_cycles),
        .stall    (stall_cycles)
    );
endmodule

// File: rtl/dram_refresh_chk.sv
module dram_refresh_chk #(
    parameter int unsigned ROWS       = 16384,
    parameter int unsigned WINDOW     = 50000000,
    parameter int unsigned REF_CYCLES = 100,
    parameter int unsigned ACC_CYCLES = 4,
    parameter int unsigned CNT_W      = 32,
    parameter int unsigned ROW_W      = $clog2(ROWS)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             acc_busy,
    input logic             refresh_busy,
    input logic [ROW_W-1:0] refresh_row,
    input logic [CNT_W-1:0] lost_cycles,
    input logic [CNT_W-1:0] stall_cycles
);
    localparam logic [ROW_W-1:0] TOP     = ROW_W'(ROWS - 1);
    localparam logic [ROW_W-1:0] AFTER_0 = ROW_W'(1 % ROWS);

    logic [31:0] ref_run_q, acc_run_q, age_q;
    logic        busy_prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_run_q   <= '0;
            acc_run_q   <= '0;
            age_q       <= '0;
            busy_prev_q <= 1'b0;
        end else begin
            ref_run_q   <= refresh_busy ? ref_run_q + 1 : '0;
            acc_run_q   <= acc_busy ? acc_run_q + 1 : '0;
            busy_prev_q <= refresh_busy;
            if (busy_prev_q && !refresh_busy && refresh_row == AFTER_0) age_q <= '0;
            else age_q <= age_q + 1;
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        $rose(rst_n) |-> !refresh_busy && !acc_busy && refresh_row == '0);

    assert_ref_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_prev_q && !refresh_busy) |-> ref_run_q == REF_CYCLES);

    assert_row_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_prev_q && !refresh_busy) |->
        refresh_row == (($past(refresh_row) == TOP) ? '0 : $past(refresh_row) + 1'b1));

    assert_row_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy |=> $stable(refresh_row) || !refresh_busy);

    assert_acc_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> acc_busy);

    assert_acc_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_run_q != 0 && !acc_busy) |-> acc_run_q == ACC_CYCLES);

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({refresh_busy, acc_busy, req_ready}));

    assert_lost_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        refresh_busy |=> lost_cycles == $past(lost_cycles) + 1'b1);

    assert_lost_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !refresh_busy |=> $stable(lost_cycles));

    assert_stall_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> stall_cycles == $past(stall_cycles) + 1'b1);

    assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_ready) |=> $stable(stall_cycles));

    // Rows are refreshed in strict order, so the age of row 0 bounds each row's gap.
    assert_retention_R10: assert property (@(posedge clk) disable iff (!rst_n)
        age_q < WINDOW);
endmodule

bind dram_refresh_sched dram_refresh_chk #(
    .ROWS(ROWS), .WINDOW(WINDOW), .REF_CYCLES(REF_CYCLES),
    .ACC_CYCLES(ACC_CYCLES), .CNT_W(CNT_W), .ROW_W(ROW_W)
) u_chk (.*);

// File: tb/dram_refresh_sched_test.sv
module dram_refresh_sched_test;
    localparam int CLK_PERIOD = 10;
    localparam int ROWS = 16, INTERVAL = 61, REF_C = 2, ACC_C = 3, WINDOW = 1100;
    localparam int ROW_W = 4, CNT_W = 32;

    typedef struct packed { int off; int wait_exp; } vec_t;
    localparam vec_t VECS [6] = '{
        '{off: 0,  wait_exp: 0}, '{off: 10, wait_exp: 0}, '{off: 57, wait_exp: 0},
        '{off: 58, wait_exp: 3}, '{off: 59, wait_exp: 2}, '{off: 60, wait_exp: 1}};

    logic clk = 0, rst_n = 0, req_valid = 0;
    logic req_ready, acc_busy, refresh_busy;
    logic [ROW_W-1:0] refresh_row;
    logic [CNT_W-1:0] lost_cycles, stall_cycles;
    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_refresh_sched #(.ROWS(ROWS), .WINDOW(WINDOW), .INTERVAL(INTERVAL),
        .REF_CYCLES(REF_C), .ACC_CYCLES(ACC_C), .CNT_W(CNT_W), .ROW_W(ROW_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .acc_busy(acc_busy), .refresh_busy(refresh_busy), .refresh_row(refresh_row),
        .lost_cycles(lost_cycles), .stall_cycles(stall_cycles));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_fall();
        while (!refresh_busy) step();
        while (refresh_busy) step();
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            finish_run();
        end
    end

    initial begin
        int rise_t[17];
        int rise_row[17];
        int lost_at[17];
        int t, nr, run;
        bit prev;
        repeat (3) step();
        check(!refresh_busy && !acc_busy, "R1 busy flags", {refresh_busy, acc_busy}, 0);
        check(refresh_row == 0, "R1 row", refresh_row, 0);
        check(lost_cycles == 0 && stall_cycles == 0, "R1 counters", lost_cycles + stall_cycles, 0);
        check(req_ready, "R1 ready", req_ready, 1);
        rst_n = 1;

        // Idle sweep: spacing, width, row order, overhead share
        t = 0; nr = 0; prev = 0; run = 0;
        while (nr < 17) begin
            step(); t++;
            if (refresh_busy && !prev) begin
                rise_t[nr] = t; rise_row[nr] = refresh_row; lost_at[nr] = lost_cycles; nr++;
            end
            if (refresh_busy) run++;
            if (!refresh_busy && prev) begin
                check(run == REF_C, "R3 refresh width", run, REF_C);
                run = 0;
            end
            prev = refresh_busy;
        end
        for (int k = 1; k < 17; k++) begin
            check(rise_t[k] - rise_t[k-1] == INTERVAL, "R2 refresh spacing", rise_t[k] - rise_t[k-1], INTERVAL);
            check(rise_row[k] == (rise_row[k-1] + 1) % ROWS, "R4 row order", rise_row[k], (rise_row[k-1] + 1) % ROWS);
        end
        check(rise_row[0] == 0, "R4 first row", rise_row[0], 0);
        check(lost_at[16] - lost_at[0] == ROWS * REF_C, "R8 lost per sweep", lost_at[16] - lost_at[0], ROWS * REF_C);
        begin
            int pm;
            pm = (lost_at[16] - lost_at[0]) * 1000 / (rise_t[16] - rise_t[0]);
            check(pm >= 30 && pm <= 36, "R8 refresh share per mille", pm, 33);
        end
        check(rise_row[16] == rise_row[0] && rise_t[16] - rise_t[0] <= WINDOW,
              "R10 same-row gap", rise_t[16] - rise_t[0], WINDOW);

        // Table: request placed at an offset after a refresh ends
        foreach (VECS[i]) begin
            int w, s0, n;
            wait_fall(); wait_fall();
            repeat (VECS[i].off) step();
            req_valid = 1;
            s0 = stall_cycles; w = 0;
            while (!req_ready) begin step(); w++; end
            check(w == VECS[i].wait_exp, "R6 request wait", w, VECS[i].wait_exp);
            step();
            req_valid = 0;
            check(acc_busy, "R5 access start", acc_busy, 1);
            n = 0;
            while (acc_busy) begin n++; step(); end
            check(n == ACC_C, "R5 access length", n, ACC_C);
            check(stall_cycles - s0 == w, "R9 stall count", stall_cycles - s0, w);
        end

        // Refresh due during an access beats a request held waiting
        begin
            int first_ref, second_acc, o;
            bit rdy60;
            wait_fall(); wait_fall();
            repeat (56) step();
            req_valid = 1;
            step();
            first_ref = -1; second_acc = -1; rdy60 = 1;
            for (o = 57; o < 80 && second_acc < 0; o++) begin
                if (o == 60) rdy60 = req_ready;
                if (refresh_busy && first_ref < 0) first_ref = o;
                if (req_ready && second_acc < 0) second_acc = o;
                if (second_acc < 0) step();
            end
            step();
            req_valid = 0;
            check(!rdy60, "R6 ready low while refresh due", rdy60, 0);
            check(first_ref == 61, "R7 refresh after access", first_ref, 61);
            check(second_acc == 63, "R7 waiting request after refresh", second_acc, 63);
            repeat (5) step();
        end

        finished = 1;
        finish_run();
    end
endmodule